// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits beside a first-level direct-mapped cache, on the refill side. When the cache reports a lookup miss that the buffer cannot serve, the buffer discards what it holds and begins fetching the lines that follow the missed line. The cache's own refill path fetches the missed line itself. The prefetched lines are kept in a small ring of entries inside the buffer and never go into the cache. Each entry holds a line address (its tag), an available flag and one line of data.

A later lookup is compared only with the oldest entry, the head. If the head matches and its data has arrived, the line is handed back in the same cycle. The entry is then retired, which frees a slot for the next sequential address. If the head matches but its data is still on the way, the requester is told to wait. Any other lookup restarts the stream.

Toward the next memory level the block issues line requests through a valid/ready handshake. Several requests can be in flight at once. Responses come back in request order and carry an epoch value that the next level copies back from the request. Responses that belong to a stream already abandoned are dropped.

Top module: `stream_buffer`

## Requirements
- R1: After reset, req_valid_o, hit_o and stall_o are all 0, and no request is issued until the first lookup.
- R2: A lookup (miss_valid_i=1) that does not match an allocated head gives hit_o=0 and stall_o=0 in that cycle, and it flushes the buffer. The next requests accepted carry line addresses miss_addr_i+1, +2, +3 and so on. A request accepted in the flush cycle itself belongs to the stream that was abandoned.
- R3: At most DEPTH lines are allocated at once. Once DEPTH requests have been accepted and no entry has been retired, req_valid_o stays 0.
- R4: A response whose epoch is current writes its data into the oldest allocated entry whose data has not yet arrived. Responses fill entries in request order.
- R5: A lookup whose address equals the head tag while the head data is available raises hit_o in the same cycle. hit_data_o then shows that line, and the entry is retired at the next clock edge.
- R6: A lookup that matches the head while the head data is not yet available raises stall_o and keeps hit_o at 0. No request is issued for that line again. The held lookup turns into a hit once the response arrives.
- R7: After an entry is retired, one further request is issued for the next sequential line address.
- R8: Only the head is compared. A lookup whose address matches a deeper entry still flushes the buffer, and prefetching restarts at that address plus one.
- R9: req_epoch_o changes only in the cycle after a flush. A response whose rsp_epoch_i differs from the current epoch is discarded, and the entry it would have filled stays unavailable.
- R10: While there is free space, requests are issued on consecutive cycles without waiting for responses.
- R11: While req_valid_o=1 and req_ready_i=0, and no flush occurs, req_valid_o stays 1 and req_addr_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Cache lookup miss presented to the buffer |
| miss_addr_i | input | ADDR_W | Line address of the missed access |
| hit_o | output | 1 | Head matched and its data is available |
| stall_o | output | 1 | Head matched but its data is still in flight |
| hit_data_o | output | LINE_W | Line data of the head entry |
| req_valid_o | output | 1 | Prefetch request to the next level |
| req_ready_i | input | 1 | Next level accepts the request |
| req_addr_o | output | ADDR_W | Line address requested |
| req_epoch_o | output | EPOCH_W | Stream epoch attached to the request |
| rsp_valid_i | input | 1 | Response from the next level, delivered in request order |
| rsp_epoch_i | input | EPOCH_W | Epoch copied back from the matching request |
| rsp_data_i | input | LINE_W | Returned line data |

## Verification
The bench uses the default configuration: four entries, 16-byte lines and 28-bit line addresses. With only four slots, the buffer fills after four back-to-back requests, so the space limit, the retire-then-refetch step and a fully allocated ring are all reached within a few cycles. The four stale responses left in flight by a flush are about as many as a 2-bit epoch has to keep apart, so a dropped response is easy to tell from an accepted one by the data it would have written. A lookup held while the next level stalls, and a match two entries deep, cover the ordering rules at small cost.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_WAIT  = 2'd2,
    LK_FLUSH = 2'd3
  } lookup_e;
endpackage

// File: rtl/sb_ptr.sv
module sb_ptr #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clr_i)    ptr_q <= '0;
    else if (inc_i)    ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 28,
  parameter int LINE_W = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_en_i,
  input  logic [PTR_W-1:0]  alloc_idx_i,
  input  logic [ADDR_W-1:0] alloc_tag_i,
  input  logic              fill_en_i,
  input  logic [PTR_W-1:0]  fill_idx_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_tag_o,
  output logic              rd_avail_o,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] tag_q   [DEPTH];
  logic              avail_q [DEPTH];
  logic [LINE_W-1:0] data_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic alloc_here, fill_here;
    assign alloc_here = alloc_en_i && (alloc_idx_i == PTR_W'(e));
    assign fill_here  = fill_en_i  && (fill_idx_i  == PTR_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[e]   <= '0;
        avail_q[e] <= 1'b0;
      end else if (alloc_here) begin
        tag_q[e]   <= alloc_tag_i;
        avail_q[e] <= 1'b0;
      end else if (fill_here) begin
        avail_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill_here) data_q[e] <= fill_data_i;
    end
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_avail_o = avail_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/stream_buffer.sv
module stream_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 28,
  parameter int LINE_W  = 128,
  parameter int EPOCH_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [ADDR_W-1:0]  miss_addr_i,
  output logic               hit_o,
  output logic               stall_o,
  output logic [LINE_W-1:0]  hit_data_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [EPOCH_W-1:0] req_epoch_o,
  input  logic               rsp_valid_i,
  input  logic [EPOCH_W-1:0] rsp_epoch_i,
  input  logic [LINE_W-1:0]  rsp_data_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HEAD = 0, TAIL = 1, FILL = 2, NPTR = 3;

  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  next_addr_q;
  logic [EPOCH_W-1:0] epoch_q;

  logic [PTR_W-1:0]   ptr   [NPTR];
  logic [NPTR-1:0]    ptr_inc;
  logic [ADDR_W-1:0]  head_tag;
  logic               head_avail;
  logic [LINE_W-1:0]  head_data;

  lookup_e lk;
  logic    head_match, flush, pop, alloc, take;

  assign head_match = (cnt_q != '0) && (head_tag == miss_addr_i);

  always_comb begin
    if (!miss_valid_i)   lk = LK_IDLE;
    else if (head_match) lk = head_avail ? LK_HIT : LK_WAIT;
    else                 lk = LK_FLUSH;
  end

  assign flush = (lk == LK_FLUSH);
  assign pop   = (lk == LK_HIT);

  // a request accepted during a flush keeps the old epoch; its response is dropped
  assign req_valid_o = active_q && (cnt_q < CNT_W'(DEPTH));
  assign req_addr_o  = next_addr_q;
  assign req_epoch_o = epoch_q;
  assign alloc = req_valid_o && req_ready_i && !flush;
  assign take  = rsp_valid_i && (rsp_epoch_i == epoch_q) && !flush;

  assign ptr_inc[HEAD] = pop;
  assign ptr_inc[TAIL] = alloc;
  assign ptr_inc[FILL] = take;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    sb_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (flush),
      .inc_i  (ptr_inc[p]),
      .ptr_o  (ptr[p])
    );
  end

  sb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (alloc),
    .alloc_idx_i (ptr[TAIL]),
    .alloc_tag_i (next_addr_q),
    .fill_en_i   (take),
    .fill_idx_i  (ptr[FILL]),
    .fill_data_i (rsp_data_i),
    .rd_idx_i    (ptr[HEAD]),
    .rd_tag_o    (head_tag),
    .rd_avail_o  (head_avail),
    .rd_data_o   (head_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      cnt_q       <= '0;
      next_addr_q <= '0;
      epoch_q     <= '0;
    end else if (flush) begin
      active_q    <= 1'b1;
      cnt_q       <= '0;
      next_addr_q <= miss_addr_i + ADDR_W'(1);
      epoch_q     <= epoch_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
      if (alloc) next_addr_q <= next_addr_q + ADDR_W'(1);
    end
  end

  assign hit_o      = pop;
  assign stall_o    = (lk == LK_WAIT);
  assign hit_data_o = head_data;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 28,
  parameter int EPOCH_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               miss_valid_i,
  input logic [ADDR_W-1:0]  miss_addr_i,
  input logic               hit_o,
  input logic               stall_o,
  input logic               req_valid_o,
  input logic               req_ready_i,
  input logic [ADDR_W-1:0]  req_addr_o,
  input logic [EPOCH_W-1:0] req_epoch_o
);
  localparam int MW = $clog2(DEPTH + 1) + 1;

  logic              flush_seen, acc;
  logic [ADDR_W-1:0] exp_addr_q;
  logic [MW-1:0]     held_q;

  assign flush_seen = miss_valid_i && !hit_o && !stall_o;
  assign acc        = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_addr_q <= '0;
      held_q     <= '0;
    end else if (flush_seen) begin
      exp_addr_q <= miss_addr_i + ADDR_W'(1);
      held_q     <= '0;
    end else begin
      if (acc) exp_addr_q <= req_addr_o + ADDR_W'(1);
      held_q <= held_q + MW'(acc) - MW'(hit_o);
    end
  end

  p_hit_stall_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && stall_o));

  p_seq_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> req_addr_o == exp_addr_q);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q <= MW'(DEPTH));

  p_hit_has_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (miss_valid_i && held_q != '0));

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !flush_seen) |=> (req_valid_o && $stable(req_addr_o)));

  p_epoch_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_seen |=> $stable(req_epoch_o));
endmodule

bind stream_buffer sb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)) u_sb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .miss_valid_i (miss_valid_i),
  .miss_addr_i  (miss_addr_i),
  .hit_o        (hit_o),
  .stall_o      (stall_o),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_addr_o   (req_addr_o),
  .req_epoch_o  (req_epoch_o)
);

// File: tb/tb_stream_buffer.sv
`timescale 1ns/1ps
module tb_stream_buffer;
  localparam int DEPTH = 4, ADDR_W = 28, LINE_W = 128, EPOCH_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic miss_valid = 1'b0, req_ready = 1'b1, rsp_valid = 1'b0;
  logic [ADDR_W-1:0]  miss_addr = '0;
  logic [EPOCH_W-1:0] rsp_epoch = '0;
  logic [LINE_W-1:0]  rsp_data = '0;
  logic hit, stall, req_valid;
  logic [LINE_W-1:0]  hit_data;
  logic [ADDR_W-1:0]  req_addr;
  logic [EPOCH_W-1:0] req_epoch;

  always #2 clk = ~clk;

  stream_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .EPOCH_W(EPOCH_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
    .hit_o(hit), .stall_o(stall), .hit_data_o(hit_data),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_epoch_o(req_epoch), .rsp_valid_i(rsp_valid), .rsp_epoch_i(rsp_epoch),
    .rsp_data_i(rsp_data)
  );

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [EPOCH_W-1:0] epoch;
    int unsigned        cyc;
  } req_t;

  req_t        pend[$];
  req_t        seen[$];
  int unsigned cyc = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_ni && req_valid && req_ready) begin
      pend.push_back('{req_addr, req_epoch, cyc});
      seen.push_back('{req_addr, req_epoch, cyc});
    end
  end

  function automatic logic [LINE_W-1:0] pat(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return {w ^ 32'hC0DE_0000, w, ~w, w + 32'h1111_1111};
  endfunction

  task automatic check(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present a lookup; checks taken 1 ns after the negedge
  task automatic lookup(input logic [ADDR_W-1:0] a, input bit exp_hit, input bit exp_stall,
                        input bit chk_data, input string req);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
    #1;
    check({req, " hit"}, LINE_W'(hit), LINE_W'(exp_hit));
    check({req, " stall"}, LINE_W'(stall), LINE_W'(exp_stall));
    if (chk_data) check({req, " data"}, hit_data, pat(a));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic respond(input logic [LINE_W-1:0] data_override, input bit use_override);
    req_t r;
    @(negedge clk);
    r = pend.pop_front();
    rsp_valid = 1'b1; rsp_epoch = r.epoch;
    rsp_data  = use_override ? data_override : pat(r.addr);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [ADDR_W-1:0] A = 28'h0000100;
  localparam logic [ADDR_W-1:0] B = 28'h0002000;

  task automatic t_reset;
    @(negedge clk);
    check("R1 req_valid", LINE_W'(req_valid), '0);
    check("R1 hit", LINE_W'(hit), '0);
    check("R1 stall", LINE_W'(stall), '0);
    check("R1 no request", LINE_W'(seen.size()), '0);
  endtask

  task automatic t_start;
    lookup(A, 0, 0, 0, "R2 flush on empty");
    idle(8);
    check("R2 request count", LINE_W'(seen.size()), LINE_W'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 sequential addr", LINE_W'(seen[i].addr), LINE_W'(A + ADDR_W'(i + 1)));
      check("R10 back to back", LINE_W'(seen[i].cyc - seen[0].cyc), LINE_W'(i));
    end
    check("R3 stops when full", LINE_W'(req_valid), '0);
  endtask

  task automatic t_fill_hit;
    respond('0, 0);
    respond('0, 0);
    lookup(A + 1, 1, 0, 1, "R4 R5 first head");
    idle(3);
    check("R7 refetch count", LINE_W'(seen.size()), LINE_W'(DEPTH + 1));
    check("R7 refetch addr", LINE_W'(seen[seen.size()-1].addr), LINE_W'(A + 5));
    lookup(A + 2, 1, 0, 1, "R4 R5 second head");
    idle(3);
  endtask

  task automatic t_stall;
    int n0;
    n0 = seen.size();
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = A + 3;
    #1;
    check("R6 stall", LINE_W'(stall), 1);
    check("R6 no hit", LINE_W'(hit), 0);
    idle(2);
    check("R6 no request while waiting", LINE_W'(seen.size()), LINE_W'(n0));
    respond('0, 0);
    #1;
    check("R6 hit after data", LINE_W'(hit), 1);
    check("R6 data", hit_data, pat(A + 3));
    @(negedge clk);
    miss_valid = 1'b0;
    idle(3);
    check("R7 after stall hit", LINE_W'(seen[seen.size()-1].addr), LINE_W'(A + 7));
  endtask

  task automatic t_deep_and_epoch;
    int n0;
    logic [EPOCH_W-1:0] old_ep;
    n0 = seen.size();
    old_ep = req_epoch;
    lookup(A + 5, 0, 0, 0, "R8 deep match flushes");
    idle(6);
    check("R8 restart addr", LINE_W'(seen[n0].addr), LINE_W'(A + 6));
    check("R9 epoch advanced", LINE_W'(seen[n0].epoch), LINE_W'(old_ep + 1'b1));
    for (int i = 0; i < 4; i++) respond('1, 1);   // stale responses
    lookup(A + 6, 0, 1, 0, "R9 stale response dropped");
    respond('0, 0);
    lookup(A + 6, 1, 0, 1, "R9 R4 fresh response");
    idle(3);
  endtask

  task automatic t_hold;
    int n0;
    @(negedge clk);
    req_ready = 1'b0;
    lookup(B, 0, 0, 0, "R11 flush");
    n0 = seen.size();
    check("R11 valid", LINE_W'(req_valid), 1);
    check("R11 addr", LINE_W'(req_addr), LINE_W'(B + 1));
    idle(3);
    check("R11 still valid", LINE_W'(req_valid), 1);
    check("R11 addr stable", LINE_W'(req_addr), LINE_W'(B + 1));
    check("R11 none accepted", LINE_W'(seen.size()), LINE_W'(n0));
    req_ready = 1'b1;
    idle(2);
    check("R11 accepted addr", LINE_W'(seen[n0].addr), LINE_W'(B + 1));
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_start();
    t_fill_hit();
    t_stall();
    t_deep_and_epoch();
    t_hold();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule